// File: doc/BRIEF.md
# I2C Target Address Match and Acknowledge Responder

This block is the bus-side front end of an I2C target with one fixed 7-bit address. It oversamples the open-drain SCL and SDA lines on the system clock, recognises start and stop conditions, and shifts in the first byte after a start. If that byte carries the block's own address, it acknowledges on the ninth clock. The direction bit then selects one of two paths. In a write transfer, every following byte is acknowledged and handed to the core with a one-cycle strobe. In a read transfer, bytes are taken from the core and shifted out, and the master's acknowledge is watched after each one.

The block never drives SDA high. `sda_oe` asserted means "pull SDA low", and the pad is expected to build the wired-AND. Neither byte path has back-pressure. `rx_valid` is a single-cycle strobe that the core must capture in that cycle, since I2C gives no room to stall without clock stretching. `tx_load` marks the cycle in which `tx_data` is sampled, and the core must present the next byte before that strobe. When the master does not acknowledge a read byte, the block lets go of SDA completely, so a stop condition can always be formed.

Top module: `i2c_ack_responder`

## Requirements
- R1: After reset `sda_oe`, `rx_valid` and `tx_load` are 0 and the block waits for a start.
- R2: A start (SDA falling while SCL is high) or a stop (SDA rising while SCL is high) releases SDA and returns the block to the address phase. This holds even in the middle of a byte, so a repeated start followed by the own address is acknowledged again.
- R3: The first byte after a start is received MSB first, and its bits 7:1 are compared with `OWN_ADDR`. On a match SDA is held low through the ninth SCL high phase. On a mismatch SDA stays released for the whole transfer, and no byte is strobed or loaded until the next start.
- R4: The acknowledge pull-down begins after the falling edge of the eighth SCL clock and is removed after the falling edge of the ninth clock, so the master's next bit reaches the bus undisturbed.
- R5: With bit 0 of the address byte equal to 0 (write), each further byte is acknowledged, and it appears MSB-first-assembled on `rx_data` with `rx_valid` high for exactly one clock cycle.
- R6: With bit 0 equal to 1 (read), `tx_load` pulses once after the address acknowledge and the sampled `tx_data` is driven MSB first, one bit per SCL clock.
- R7: After the eighth bit of a read byte the block releases SDA for the ninth clock, so the master's acknowledge level is what the bus carries.
- R8: If the master pulls SDA low on the ninth clock, the next byte is loaded through `tx_load` and its MSB is driven after that clock's falling edge.
- R9: If the master leaves SDA high on the ninth clock (NACK), the block loads no byte and keeps SDA released until the next start or stop, even if the next byte would begin with 0, so the master's stop succeeds.
- R10: `sda_oe` changes only while the sampled SCL is low, except for the release that a start or stop forces.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad (wired-AND result) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rx_data | output | 8 | Last byte written by the master |
| rx_valid | output | 1 | One-cycle strobe qualifying `rx_data` |
| tx_data | input | 8 | Next byte to send to the master |
| tx_load | output | 1 | One-cycle strobe: `tx_data` sampled this cycle |

## Verification
Two actions can coincide on one SCL falling edge: loading a new transmit byte and putting its MSB on the bus. These are provoked by read transfers where the master acknowledges. A wrong or late MSB shows up as a bit error in the byte the bench model predicts from its own copy of the transmit pool. The hand-off of SDA on that same edge is also exercised in two ways. After a master NACK, the byte that a faulty responder would load starts with 0, and the bench checks that the following stop still reaches the bus. In write transfers, the bench checks that every master bit after an acknowledge arrives intact on the wired-AND line.

// File: rtl/i2c_resp_pkg.sv
package i2c_resp_pkg;
  localparam int BYTE_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } resp_state_e;
endpackage

// File: rtl/i2c_bit_sync.sv
module i2c_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b1;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_ack_responder.sv
module i2c_ack_responder
  import i2c_resp_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR    = 7'h52,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_load
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_bit_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
  i2c_bit_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

  i2c_cond_detect u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  resp_state_e            state;
  logic [CNT_W-1:0]       bitcnt;
  logic [BYTE_BITS-1:0]   in_sh;
  logic [BYTE_BITS-1:0]   out_sh;
  logic                   read_dir;
  logic                   ack_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      in_sh    <= '0;
      out_sh   <= '0;
      read_dir <= 1'b0;
      ack_ok   <= 1'b0;
      sda_oe   <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      tx_load  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_load  <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              in_sh  <= {in_sh[BYTE_BITS-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == LAST_BIT) begin
              if (state == ST_ADDR) begin
                if (in_sh[7:1] == OWN_ADDR) begin
                  sda_oe   <= 1'b1;
                  read_dir <= in_sh[0];
                  state    <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_oe   <= 1'b1;
                rx_data  <= in_sh;
                rx_valid <= 1'b1;
                state    <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK, ST_WR_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (state == ST_ADDR_ACK && read_dir) begin
                out_sh  <= tx_data;
                tx_load <= 1'b1;
                sda_oe  <= ~tx_data[BYTE_BITS-1];
                state   <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WR;
              end
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                state  <= ST_RD_ACK;
              end else begin
                out_sh <= {out_sh[BYTE_BITS-2:0], 1'b0};
                sda_oe <= ~out_sh[BYTE_BITS-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              ack_ok <= ~sda_s;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (ack_ok) begin
                out_sh  <= tx_data;
                tx_load <= 1'b1;
                sda_oe  <= ~tx_data[BYTE_BITS-1];
                state   <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_IDLE;
              end
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end

  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

  // R5
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R2
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR && bitcnt == '0 && !sda_oe));

  // R9
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD_ACK && scl_fall && !ack_ok && !start_det && !stop_det)
      |=> (!sda_oe && !tx_load && state == ST_IDLE));

  // R3
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_ADDR) |-> !sda_oe);

  // R6
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> (state == ST_RD && bitcnt == '0));
endmodule

// File: tb/i2c_ack_responder_tb_top.sv
module i2c_ack_responder_tb_top;
  localparam logic [6:0] ADDR = 7'h52;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, scl, msda;
  logic sda_oe, rx_valid, tx_load;
  logic [7:0] rx_data, tx_data;
  wire sda_line = msda & ~sda_oe;

  logic [7:0] pool [64];
  logic [5:0] tx_idx;
  logic [5:0] ep;
  logic [7:0] rx_log [256];
  int rx_cnt, exp_rx;
  int checks, errors;

  assign tx_data = pool[tx_idx];

  i2c_ack_responder #(.OWN_ADDR(ADDR)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_data(tx_data), .tx_load(tx_load));

  always @(posedge clk) begin
    if (!rst_n) begin
      tx_idx <= '0;
      rx_cnt <= 0;
    end else begin
      if (tx_load) tx_idx <= tx_idx + 1'b1;
      if (rx_valid) begin
        rx_log[rx_cnt[7:0]] <= rx_data;
        rx_cnt <= rx_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic put_bit(input logic mb, output logic seen);
    msda = mb; wq();
    scl = 1'b1; wq();
    @(negedge clk) seen = sda_line;
    wq();
    scl = 1'b0; wq();
  endtask

  task automatic do_start();
    msda = 1'b1; wq();
    scl = 1'b1; wq();
    msda = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic do_stop(output logic line_hi);
    msda = 1'b0; wq();
    scl = 1'b1; wq();
    msda = 1'b1; wq();
    @(negedge clk) line_hi = sda_line;
    wq();
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack, output logic clean);
    logic s;
    clean = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      put_bit(b[i], s);
      if (s != b[i]) clean = 1'b0;
    end
    put_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] got, output logic free);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      put_bit(1'b1, s);
      got[i] = s;
    end
    put_bit(~mack, s);
    free = (s == ~mack);
  endtask

  function automatic logic [6:0] other_addr(input int r);
    return ADDR ^ 7'(1 + (r % 127));
  endfunction

  initial begin
    logic ack, clean, free, hi;
    logic [7:0] got, b;
    void'($urandom(32'd5150));
    checks = 0; errors = 0; exp_rx = 0; ep = '0;
    for (int k = 0; k < 64; k++) pool[k] = 8'($urandom);
    pool[0] = 8'h3C; pool[1] = 8'hC5; pool[2] = 8'h00;
    scl = 1'b1; msda = 1'b1; rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    wq();
    @(negedge clk);
    chk(sda_oe == 0 && rx_valid == 0 && tx_load == 0, "R1 reset outputs", {sda_oe, rx_valid, tx_load}, 0);

    // directed write: R3, R4, R5
    do_start();
    write_byte({ADDR, 1'b0}, ack, clean);
    chk(ack, "R3 own address acknowledged", ack, 1);
    foreach (pool[k]) if (k < 3) begin
      b = (k == 0) ? 8'hA5 : (k == 1) ? 8'h00 : 8'hFF;
      write_byte(b, ack, clean);
      exp_rx++;
      chk(ack, "R5 write byte acknowledged", ack, 1);
      chk(clean, "R4 ack released before next master bit", clean, 1);
      chk(rx_cnt == exp_rx && rx_log[exp_rx-1] == b, "R5 rx byte", rx_log[exp_rx-1], b);
    end
    do_stop(hi);
    chk(hi, "R2 stop reaches bus", hi, 1);

    // mismatch: R3
    do_start();
    write_byte({other_addr(5), 1'b0}, ack, clean);
    chk(!ack, "R3 foreign address not acknowledged", ack, 0);
    write_byte(8'h00, ack, clean);
    chk(!ack && rx_cnt == exp_rx, "R3 foreign transfer ignored", rx_cnt, exp_rx);
    do_stop(hi);

    // directed read with ack then NACK: R6 R7 R8 R9
    do_start();
    write_byte({ADDR, 1'b1}, ack, clean);
    chk(ack, "R6 read address acknowledged", ack, 1);
    read_byte(1'b1, got, free);
    chk(got == pool[ep], "R6 first read byte", got, pool[ep]); ep++;
    chk(free, "R7 released in master ack slot", free, 1);
    read_byte(1'b0, got, free);
    chk(got == pool[ep], "R8 byte after master ack", got, pool[ep]); ep++;
    chk(free, "R7 released in master NACK slot", free, 1);
    wq();
    @(negedge clk);
    chk(!sda_oe, "R9 SDA released after NACK", sda_oe, 0);
    do_stop(hi);
    chk(hi, "R9 stop after NACK", hi, 1);
    chk(tx_idx == ep, "R9 no load after NACK", tx_idx, ep);

    // repeated start mid byte: R2
    do_start();
    write_byte({ADDR, 1'b0}, ack, clean);
    for (int i = 0; i < 4; i++) put_bit(1'b0, ack);
    do_start();
    write_byte({ADDR, 1'b0}, ack, clean);
    chk(ack, "R2 repeated start re-addresses", ack, 1);
    write_byte(8'h5A, ack, clean); exp_rx++;
    chk(rx_cnt == exp_rx && rx_log[exp_rx-1] == 8'h5A, "R2 byte after restart", rx_log[exp_rx-1], 8'h5A);
    do_stop(hi);

    // random transfers
    for (int t = 0; t < 24; t++) begin
      logic match, rw;
      int n;
      match = ($urandom % 4) != 0;
      rw = $urandom % 2;
      n = 1 + $urandom % 3;
      do_start();
      write_byte({match ? ADDR : other_addr(int'($urandom % 1000)), rw}, ack, clean);
      chk(ack == match, "R3 address decision", ack, match);
      if (!match) begin
        write_byte(8'($urandom), ack, clean);
        chk(!ack && rx_cnt == exp_rx, "R3 ignored after mismatch", rx_cnt, exp_rx);
      end else if (!rw) begin
        for (int j = 0; j < n; j++) begin
          b = 8'($urandom);
          write_byte(b, ack, clean); exp_rx++;
          chk(ack && clean && rx_log[exp_rx-1] == b, "R5 random write", rx_log[exp_rx-1], b);
        end
      end else begin
        for (int j = 0; j < n; j++) begin
          read_byte(j != n-1, got, free);
          chk(got == pool[ep] && free, "R8 random read", got, pool[ep]); ep++;
        end
      end
      do_stop(hi);
      chk(hi, "R9 stop line high", hi, 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule